// File: doc/BRIEF.md
# Stepper Driver Power-Mode Controller

This block is the supervisory logic of a stepper motor driver. It decides which internal subsystems run (H-bridge output stage, charge pump, logic regulator and step indexer) from a run/sleep pin, a drive-enable pin and five fault flags. It also keeps the step position that stands in for the indexer. Entry into sleep and recovery from it are timed in clock cycles.

The step input is synchronized and edge-detected. Each rising edge moves the position by one while the indexer runs, including while the output stage is off. A separate phase output carries the position to the output stage, and it only follows the position while the bridge is enabled. A logic-supply undervoltage acts as an internal reset. It returns the position to home and restarts the wake delay. Every other fault only masks outputs.

Top module: `stepper_power_ctrl`

## Requirements
- R1: With `run_pin` held low for SLEEP_CYC cycles, the block enters sleep. `reg_en`, `pump_en`, `index_active` and `bridge_en` are all 0.
- R2: During the sleep delay, the block stays fully awake. If `run_pin` returns high before the delay ends, sleep entry is cancelled and the bridge continues without a new wake delay.
- R3: A high `run_pin` wakes a sleeping block. `reg_en` and `pump_en` come on within two cycles, and `bridge_en` stays 0 for at least WAKE_CYC cycles before it may rise.
- R4: `drive_en` low forces `bridge_en` to 0. `pump_en`, `reg_en` and `index_active` remain 1.
- R5: Each rising edge of `step_in` while `index_active` is 1 adds exactly one to `position`. `position` counts 0 to POS_COUNT-1 and wraps from POS_COUNT-1 to 0.
- R6: `phase` copies `position` while `bridge_en` is 1 and holds its value while `bridge_en` is 0.
- R7: `vm_uv` high forces `bridge_en` and `pump_en` to 0, keeps `reg_en` and `index_active` at 1, and step edges still advance `position`.
- R8: `logic_uv` high clears `position` and `phase` to 0 (home) and forces `bridge_en`, `pump_en` and `index_active` to 0 while `reg_en` stays 1. After it clears, the wake delay of R3 runs again before `bridge_en` returns.
- R9: `cp_uv`, `over_temp` or `over_cur` high forces only `bridge_en` to 0. `pump_en`, `reg_en` and `index_active` stay 1.
- R10: When the last fault clears, `bridge_en` returns to 1 on the next clock edge. It is not yet 1 in the cycle in which the fault is removed.
- R11: While asleep, step edges are ignored, and `position` keeps its value through sleep and wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_pin | input | 1 | High = run, low = request sleep |
| drive_en | input | 1 | Output stage enable request |
| step_in | input | 1 | Asynchronous step pulse |
| vm_uv | input | 1 | Motor supply undervoltage |
| logic_uv | input | 1 | Logic supply undervoltage |
| cp_uv | input | 1 | Charge pump undervoltage |
| over_temp | input | 1 | Thermal shutdown |
| over_cur | input | 1 | Overcurrent |
| bridge_en | output | 1 | H-bridge output enable |
| pump_en | output | 1 | Charge pump enable |
| reg_en | output | 1 | Logic regulator enable |
| index_active | output | 1 | Indexer running |
| position | output | $clog2(POS_COUNT) | Indexer step position |
| phase | output | $clog2(POS_COUNT) | Position presented to the output stage |

## Verification
The assertions assume that the fault flags, `run_pin` and `drive_en` are already synchronous to `clk` and are held steady between clock edges. Only `step_in` may be asynchronous. The bench changes every input on the falling clock edge. It holds each step pulse high and low for three cycles, so every pulse crosses the two-flop synchronizer as a single clean edge. Fault combinations are applied one at a time so that the effect of each flag can be seen on its own.

// File: rtl/spc_pkg.sv
// Package: shared types for the stepper power-mode controller.
// Assumes nothing beyond IEEE 1800-2017.
package spc_pkg;
    typedef enum logic [1:0] {
        SEQ_ASLEEP = 2'd0,
        SEQ_WAKING = 2'd1,
        SEQ_AWAKE  = 2'd2,
        SEQ_PEND   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/spc_step_sync.sv
// Module: spc_step_sync
// Brings the asynchronous step pin into the clock domain through a
// SYNC_STAGES flop chain and emits a one-cycle pulse per rising edge.
// Assumes pulses are held at least two clocks high and low.
module spc_step_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    output logic step_edge
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    // Shift the pin through the synchronizer and keep the previous stable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[SYNC_STAGES-2:0], step_in};
            last_q <= chain[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronized value.
    always_comb begin
        step_edge = chain[SYNC_STAGES-1] & ~last_q;
    end

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_edge |=> !step_edge);
endmodule

// File: rtl/spc_power_seq.sv
// Module: spc_power_seq
// Sleep/wake sequencer. A low run pin starts a SLEEP_CYC countdown that a
// high pin cancels; a high pin in sleep starts a WAKE_CYC countdown before
// woke is set. A logic undervoltage restarts the wake countdown.
// Assumes run_pin and logic_uv are synchronous to clk.
module spc_power_seq
    import spc_pkg::*;
#(
    parameter int SLEEP_CYC = 16,
    parameter int WAKE_CYC  = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_pin,
    input  logic logic_uv,
    output logic powered,
    output logic woke
);
    localparam int MAXC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;

    // State and delay counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_ASLEEP;
            cnt   <= '0;
            woke  <= 1'b0;
        end else begin
            case (state)
                SEQ_ASLEEP: begin
                    if (run_pin) begin
                        state <= SEQ_WAKING;
                        cnt   <= '0;
                    end
                end
                SEQ_WAKING: begin
                    if (logic_uv) begin
                        cnt <= '0;
                    end else if (!run_pin) begin
                        state <= SEQ_PEND;
                        cnt   <= '0;
                    end else if (cnt == CW'(WAKE_CYC - 1)) begin
                        state <= SEQ_AWAKE;
                        woke  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_AWAKE: begin
                    if (logic_uv) begin
                        state <= SEQ_WAKING;
                        cnt   <= '0;
                        woke  <= 1'b0;
                    end else if (!run_pin) begin
                        state <= SEQ_PEND;
                        cnt   <= '0;
                    end
                end
                default: begin
                    if (run_pin) begin
                        if (woke && !logic_uv) begin
                            state <= SEQ_AWAKE;
                        end else begin
                            state <= SEQ_WAKING;
                            cnt   <= '0;
                            woke  <= 1'b0;
                        end
                    end else if (cnt == CW'(SLEEP_CYC - 1)) begin
                        state <= SEQ_ASLEEP;
                        cnt   <= '0;
                        woke  <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (logic_uv) woke <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Everything except full sleep counts as powered.
    always_comb begin
        powered = (state != SEQ_ASLEEP);
    end

    p_woke_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(woke) |-> $past(state) == SEQ_WAKING);
    p_sleep_via_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ASLEEP && $past(state) != SEQ_ASLEEP) |-> $past(state) == SEQ_PEND);
    p_no_woke_asleep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ASLEEP) |-> !woke);
endmodule

// File: rtl/spc_indexer.sv
// Module: spc_indexer
// Step position counter modulo POS_COUNT, and the phase register that the
// output stage sees. Phase follows position only while show is high.
// Assumes advance is a single-cycle pulse.
module spc_indexer #(
    parameter int POS_COUNT = 32,
    localparam int PW = $clog2(POS_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          active,
    input  logic          advance,
    input  logic          show,
    output logic [PW-1:0] position,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(POS_COUNT - 1);

    // Advance and wrap the step position; a clear returns it home.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            position <= '0;
        end else if (active && advance) begin
            position <= (position == LAST) ? '0 : position + 1'b1;
        end
    end

    // Present the position to the output stage only while it is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= '0;
        end else if (show) begin
            phase <= position;
        end
    end

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && active && advance && position == LAST) |=> position == '0);
    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && active && advance && position != LAST) |=> position == $past(position) + 1'b1);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(active && advance)) |=> $stable(position));
    p_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (position == '0 && phase == '0));
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !show) |=> $stable(phase));
endmodule

// File: rtl/stepper_power_ctrl.sv
// Module: stepper_power_ctrl (top)
// Decides which driver subsystems run from the run pin, the enable pin and
// the fault flags, and keeps the step position.
// Assumes the fault flags, run_pin and drive_en are synchronous level inputs;
// step_in may be asynchronous.
module stepper_power_ctrl #(
    parameter int SLEEP_CYC   = 16,
    parameter int WAKE_CYC    = 24,
    parameter int POS_COUNT   = 32,
    parameter int SYNC_STAGES = 2,
    localparam int PW = $clog2(POS_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_pin,
    input  logic          drive_en,
    input  logic          step_in,
    input  logic          vm_uv,
    input  logic          logic_uv,
    input  logic          cp_uv,
    input  logic          over_temp,
    input  logic          over_cur,
    output logic          bridge_en,
    output logic          pump_en,
    output logic          reg_en,
    output logic          index_active,
    output logic [PW-1:0] position,
    output logic [PW-1:0] phase
);
    logic powered;
    logic woke;
    logic step_edge;
    logic bridge_d;
    logic bridge_q;
    logic any_fault;

    spc_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .step_edge(step_edge)
    );

    spc_power_seq #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_pin(run_pin), .logic_uv(logic_uv),
        .powered(powered), .woke(woke)
    );

    spc_indexer #(.POS_COUNT(POS_COUNT)) u_idx (
        .clk(clk), .rst_n(rst_n), .clear(logic_uv), .active(index_active),
        .advance(step_edge), .show(bridge_en), .position(position), .phase(phase)
    );

    // Subsystem enables from power state and fault flags.
    always_comb begin
        any_fault    = vm_uv | logic_uv | cp_uv | over_temp | over_cur;
        reg_en       = powered;
        pump_en      = powered & ~vm_uv & ~logic_uv;
        index_active = powered & ~logic_uv;
        bridge_d     = woke & drive_en & ~any_fault;
        bridge_en    = bridge_q & powered;
    end

    // Register the bridge permission so it changes one edge after its inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) bridge_q <= 1'b0;
        else        bridge_q <= bridge_d;
    end

    p_sleep_all_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> (!pump_en && !index_active && !bridge_en));
    p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> !bridge_en);
    p_vm_uv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_uv && !logic_uv) |-> (!pump_en && index_active == reg_en));
    p_fault_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_uv || over_temp || over_cur) |=> !bridge_en);
    p_lv_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        logic_uv |=> (!bridge_en && position == '0));
endmodule

// File: tb/sim_stepper_power_ctrl.sv
module sim_stepper_power_ctrl;
    localparam int SC = 6;
    localparam int WC = 8;
    localparam int PC = 6;
    localparam int PW = $clog2(PC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_pin = 1'b0, drive_en = 1'b0, step_in = 1'b0;
    logic vm_uv = 1'b0, logic_uv = 1'b0, cp_uv = 1'b0, over_temp = 1'b0, over_cur = 1'b0;
    logic bridge_en, pump_en, reg_en, index_active;
    logic [PW-1:0] position, phase;

    int checks = 0;
    int errors = 0;
    int exp_pos = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stepper_power_ctrl #(.SLEEP_CYC(SC), .WAKE_CYC(WC), .POS_COUNT(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .run_pin(run_pin), .drive_en(drive_en),
        .step_in(step_in), .vm_uv(vm_uv), .logic_uv(logic_uv), .cp_uv(cp_uv),
        .over_temp(over_temp), .over_cur(over_cur), .bridge_en(bridge_en),
        .pump_en(pump_en), .reg_en(reg_en), .index_active(index_active),
        .position(position), .phase(phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_step();
        step_in = 1'b1; wait_n(3);
        step_in = 1'b0; wait_n(3);
    endtask

    task automatic t_reset();
        wait_n(3);
        chk("R1 reset reg_en", reg_en, 0);
        chk("R1 reset bridge_en", bridge_en, 0);
        chk("R5 reset position", position, 0);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_wake();
        drive_en = 1'b1;
        run_pin = 1'b1;
        wait_n(2);
        chk("R3 reg_en on wake", reg_en, 1);
        chk("R3 pump_en on wake", pump_en, 1);
        wait_n(WC - 3);
        chk("R3 bridge held during wake delay", bridge_en, 0);
        wait_n(4);
        chk("R3 bridge after wake delay", bridge_en, 1);
    endtask

    task automatic t_steps_wrap();
        for (int i = 0; i < PC + 2; i++) begin
            pulse_step();
            exp_pos = (exp_pos + 1) % PC;
            chk("R5 step advance/wrap", position, exp_pos);
        end
        chk("R6 phase follows while enabled", phase, exp_pos);
    endtask

    task automatic t_enable_low();
        int held;
        held = exp_pos;
        drive_en = 1'b0;
        wait_n(2);
        chk("R4 bridge off", bridge_en, 0);
        chk("R4 pump stays", pump_en, 1);
        chk("R4 indexer stays", index_active, 1);
        pulse_step(); exp_pos = (exp_pos + 1) % PC;
        pulse_step(); exp_pos = (exp_pos + 1) % PC;
        chk("R4 steps advance while disabled", position, exp_pos);
        chk("R6 phase holds while disabled", phase, held);
        drive_en = 1'b1;
        wait_n(3);
        chk("R6 phase updates on enable", phase, exp_pos);
    endtask

    task automatic t_vm_uv();
        vm_uv = 1'b1;
        wait_n(2);
        chk("R7 bridge off", bridge_en, 0);
        chk("R7 pump off", pump_en, 0);
        chk("R7 reg on", reg_en, 1);
        chk("R7 indexer on", index_active, 1);
        pulse_step(); exp_pos = (exp_pos + 1) % PC;
        chk("R7 step advances", position, exp_pos);
        vm_uv = 1'b0;
        wait_n(2);
    endtask

    task automatic t_faults();
        for (int k = 0; k < 3; k++) begin
            if (k == 0) cp_uv = 1'b1;
            if (k == 1) over_temp = 1'b1;
            if (k == 2) over_cur = 1'b1;
            wait_n(2);
            chk("R9 bridge off on fault", bridge_en, 0);
            chk("R9 pump stays", pump_en, 1);
            chk("R9 indexer stays", index_active, 1);
            chk("R9 reg stays", reg_en, 1);
            cp_uv = 1'b0; over_temp = 1'b0; over_cur = 1'b0;
            #1;
            chk("R10 bridge not yet back", bridge_en, 0);
            wait_n(1);
            chk("R10 bridge back next edge", bridge_en, 1);
        end
    endtask

    task automatic t_logic_uv();
        logic_uv = 1'b1;
        wait_n(2);
        chk("R8 position home", position, 0);
        chk("R8 phase home", phase, 0);
        chk("R8 bridge off", bridge_en, 0);
        chk("R8 pump off", pump_en, 0);
        chk("R8 indexer off", index_active, 0);
        chk("R8 reg on", reg_en, 1);
        exp_pos = 0;
        logic_uv = 1'b0;
        wait_n(WC - 2);
        chk("R8 wake delay rerun", bridge_en, 0);
        wait_n(5);
        chk("R8 bridge back after delay", bridge_en, 1);
    endtask

    task automatic t_sleep_cancel();
        run_pin = 1'b0;
        wait_n(SC - 1);
        chk("R2 pump on during delay", pump_en, 1);
        chk("R2 bridge on during delay", bridge_en, 1);
        run_pin = 1'b1;
        wait_n(SC + 3);
        chk("R2 cancel keeps pump", pump_en, 1);
        chk("R2 cancel keeps bridge", bridge_en, 1);
    endtask

    task automatic t_sleep();
        pulse_step(); exp_pos = (exp_pos + 1) % PC;
        run_pin = 1'b0;
        wait_n(SC + 2);
        chk("R1 reg off", reg_en, 0);
        chk("R1 pump off", pump_en, 0);
        chk("R1 bridge off", bridge_en, 0);
        chk("R1 indexer off", index_active, 0);
        pulse_step();
        chk("R11 step ignored asleep", position, exp_pos);
        run_pin = 1'b1;
        wait_n(WC + 3);
        chk("R11 position kept over sleep", position, exp_pos);
        chk("R3 bridge back after wake", bridge_en, 1);
    endtask

    initial begin
        t_reset();
        t_wake();
        t_steps_wrap();
        t_enable_low();
        t_vm_uv();
        t_faults();
        t_logic_uv();
        t_sleep_cancel();
        t_sleep();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule